// File: doc/BRIEF.md
# Standard-Identifier Acceptance Filter Scanner

This block decides what happens to a received frame that carries an 11-bit identifier. Software loads a list of 32-bit filter entries into an internal RAM through a plain write port. Each entry pairs a comparison rule with an action. On a start strobe the block latches the identifier. It then walks the list from a programmable base address, one entry per clock. The walk halts at the first enabled entry that matches, or after the last entry of the list.

When the walk ends, the block pulses `done` and presents a registered verdict, which stays until the next verdict replaces it. The verdict covers several things: whether an entry matched and its position, whether the frame is stored to queue 0 or queue 1 or rejected, and whether a priority match happened. For a dedicated-slot entry it also gives the buffer address and the debug kind. Event outputs pulse with `done`, and so does an optional priority interrupt. A status pair keeps the position and queue of the most recent priority match. The configuration inputs (`list_base`, `list_len`, `buf_base`, `nomatch_reject`, `prio_irq_en`) must be held steady while `busy` is high.

Entry word layout: [31:30] rule kind, [29:27] action, [26:16] identifier A, [15:11] ignored, [10:0] identifier B.

Top module: `stdid_screen`

## Requirements
- R1: After reset, `busy`, `done`, every `res_*` output, `evt_pulse`, `prio_irq`, `stat_idx` and `stat_fifo` are zero.
- R2: Call the edge that samples `start` edge 0. `done` is high for exactly one cycle, after edge k+1 when entry k matches, after edge L when L entries give no match, and after edge 0 when L is 0. `busy` is high from edge 0 until `done` rises.
- R3: Rule kind 0 (span) matches when A <= id <= B.
- R4: Rule kind 1 (pair) matches when id equals A or id equals B.
- R5: Rule kind 2 (masked) matches when every id bit whose B bit is 1 equals the corresponding A bit. B bits that are 0 are don't-care.
- R6: Rule kind 3 never matches. An entry with action 0 is skipped whatever its rule.
- R7: The earliest matching enabled entry wins, and `res_idx` gives its position in the list (0 = first). `res_match` is 1 only when an entry matched.
- R8: Action 1 gives `res_store`=1 with `res_fifo`=0. Action 2 gives `res_store`=1 with `res_fifo`=1. Action 3 gives `res_reject`=1. Outputs that do not apply are 0.
- R9: Actions 4, 5 and 6 set `res_prio`. Action 4 stores nothing. Actions 5 and 6 also store to queue 0 or queue 1. Each such match loads `stat_idx` with the position, and loads `stat_fifo` with 0 (none), 1 (queue 0) or 2 (queue 1). Any other outcome leaves the status unchanged. `prio_irq` pulses with `done` when `res_prio` and `prio_irq_en` are both set.
- R10: Action 7 ignores the rule kind and matches only when id equals A exactly. It sets `res_dedicated`, and `res_dbg_kind` = B[10:9] (0 = buffer, 1/2/3 = debug A/B/C). `res_buf_addr` = `buf_base` + B[5:0], modulo 2^BUF_AW.
- R11: `evt_pulse[i]` is high for the single `done` cycle only when an action-7 entry matched with B[6+i] set.
- R12: With no match, `nomatch_reject`=1 gives `res_reject`=1, and 0 gives `res_store`=1 with `res_fifo`=0.
- R13: Entry n is read from RAM address (`list_base` + n) mod 2^LIST_AW. A `list_len` above MAX_ELEMS acts as MAX_ELEMS. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Filter RAM write strobe |
| wr_addr | input | LIST_AW | Filter RAM write address |
| wr_data | input | 32 | Filter entry word |
| list_base | input | LIST_AW | RAM address of list entry 0 |
| list_len | input | LEN_W | Number of list entries |
| buf_base | input | BUF_AW | Base address for dedicated buffers |
| nomatch_reject | input | 1 | No-match policy: 1 reject, 0 queue 0 |
| prio_irq_en | input | 1 | Priority interrupt enable |
| start | input | 1 | Begin a scan for `rx_id` |
| rx_id | input | 11 | Received identifier |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle verdict-valid pulse |
| res_match | output | 1 | An entry matched |
| res_idx | output | IDX_W | Position of the matching entry |
| res_store | output | 1 | Store to a queue |
| res_fifo | output | 1 | Queue select |
| res_reject | output | 1 | Frame rejected |
| res_prio | output | 1 | Priority match |
| res_dedicated | output | 1 | Dedicated-slot match |
| res_dbg_kind | output | 2 | Buffer / debug kind |
| res_buf_addr | output | BUF_AW | Dedicated buffer address |
| evt_pulse | output | 3 | Filter event pulses |
| prio_irq | output | 1 | Priority interrupt pulse |
| stat_idx | output | IDX_W | Last priority-match position |
| stat_fifo | output | 2 | Last priority-match queue code |

## Verification
All verdict fields, the event pulses and the interrupt are registered on the same edge that raises `done`. That edge is k+1 edges after the start edge for a hit at position k, L edges after it for a miss, and the start edge itself for an empty list. The bench drives `start` on a falling edge and counts falling edges until `done` is seen. It compares that count with the count its own list model predicts, and samples the whole verdict in that same half-cycle. One falling edge later it confirms that `done`, the event pulses and the interrupt have dropped, so every one-cycle pulse is checked both where it must appear and where it must be gone.

// File: rtl/stdid_pkg.sv
package stdid_pkg;
   localparam int ID_W  = 11;
   localparam int EVT_N = 3;
   localparam int OFS_W = 6;

   typedef enum logic [1:0] {
      FT_SPAN   = 2'd0,
      FT_PAIR   = 2'd1,
      FT_MASKED = 2'd2,
      FT_RSVD   = 2'd3
   } ftype_e;

   typedef enum logic [2:0] {
      AC_OFF    = 3'd0,
      AC_Q0     = 3'd1,
      AC_Q1     = 3'd2,
      AC_DROP   = 3'd3,
      AC_PRI    = 3'd4,
      AC_PRI_Q0 = 3'd5,
      AC_PRI_Q1 = 3'd6,
      AC_DIRECT = 3'd7
   } act_e;

   typedef struct packed {
      ftype_e          ftype;
      act_e            act;
      logic [ID_W-1:0] id_a;
      logic [4:0]      pad;
      logic [ID_W-1:0] id_b;
   } elem_t;

   typedef enum logic {ST_IDLE, ST_SCAN} scan_st_e;
endpackage

// File: rtl/stdid_elem_ram.sv
module stdid_elem_ram #(
   parameter int AW = 8,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/stdid_elem_match.sv
module stdid_elem_match
   import stdid_pkg::*;
(
   input  elem_t           elem,
   input  logic [ID_W-1:0] id,
   output logic            hit
);
   logic [ID_W-1:0] bit_ok;
   logic            in_span, pair_eq, masked_eq, exact_eq, rule_ok;
   logic            unused_pad;

   // per-bit masked compare: a clear mask bit makes the bit don't-care
   for (genvar b = 0; b < ID_W; b++) begin : g_mbit
      assign bit_ok[b] = ~elem.id_b[b] | ~(id[b] ^ elem.id_a[b]);
   end

   assign unused_pad = ^elem.pad;

   always_comb begin
      in_span   = (id >= elem.id_a) && (id <= elem.id_b);
      pair_eq   = (id == elem.id_a) || (id == elem.id_b);
      masked_eq = &bit_ok;
      exact_eq  = (id == elem.id_a);
      case (elem.ftype)
         FT_SPAN:   rule_ok = in_span;
         FT_PAIR:   rule_ok = pair_eq;
         FT_MASKED: rule_ok = masked_eq;
         default:   rule_ok = 1'b0;
      endcase
      case (elem.act)
         AC_OFF:    hit = 1'b0;
         AC_DIRECT: hit = exact_eq;
         default:   hit = rule_ok;
      endcase
   end
endmodule

// File: rtl/stdid_scan_ctl.sv
module stdid_scan_ctl
   import stdid_pkg::*;
#(
   parameter int LIST_AW   = 8,
   parameter int MAX_ELEMS = 128,
   parameter int BUF_AW    = 8,
   parameter int IDX_W     = 7,
   parameter int LEN_W     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ID_W-1:0]    rx_id,
   input  logic [LIST_AW-1:0] list_base,
   input  logic [LEN_W-1:0]   list_len,
   input  logic [BUF_AW-1:0]  buf_base,
   input  logic               nomatch_reject,
   input  logic               prio_irq_en,
   input  logic               elem_hit,
   input  act_e               elem_act,
   input  logic [ID_W-1:0]    elem_aux,
   output logic [LIST_AW-1:0] rd_addr,
   output logic [ID_W-1:0]    id_q,
   output logic               busy,
   output logic               done,
   output logic               res_match,
   output logic [IDX_W-1:0]   res_idx,
   output logic               res_store,
   output logic               res_fifo,
   output logic               res_reject,
   output logic               res_prio,
   output logic               res_dedicated,
   output logic [1:0]         res_dbg_kind,
   output logic [BUF_AW-1:0]  res_buf_addr,
   output logic [EVT_N-1:0]   evt_pulse,
   output logic               prio_irq,
   output logic [IDX_W-1:0]   stat_idx,
   output logic [1:0]         stat_fifo
);
   scan_st_e           state;
   logic [IDX_W-1:0]   eval_idx;
   logic [LIST_AW-1:0] base_q;
   logic [LEN_W-1:0]   len_q, len_eff;
   logic               last, launch, fin_hit, fin_miss, finish;
   logic               n_store, n_fifo, n_reject, n_prio, n_ded;
   logic [1:0]         n_sfifo;
   logic [EVT_N-1:0]   n_evt;

   assign busy = (state == ST_SCAN);

   always_comb begin
      len_eff  = (list_len > LEN_W'(MAX_ELEMS)) ? LEN_W'(MAX_ELEMS) : list_len;
      last     = (LEN_W'(eval_idx) + LEN_W'(1)) == len_q;
      rd_addr  = (state == ST_IDLE) ? list_base
                                    : base_q + LIST_AW'(eval_idx) + LIST_AW'(1);
      launch   = (state == ST_IDLE) && start && (len_eff != '0);
      fin_hit  = (state == ST_SCAN) && elem_hit;
      fin_miss = ((state == ST_SCAN) && !elem_hit && last) ||
                 ((state == ST_IDLE) && start && (len_eff == '0));
      finish   = fin_hit || fin_miss;

      n_store  = 1'b0;
      n_fifo   = 1'b0;
      n_reject = 1'b0;
      n_prio   = 1'b0;
      n_ded    = 1'b0;
      n_sfifo  = 2'd0;
      if (fin_hit) begin
         case (elem_act)
            AC_Q0:     n_store = 1'b1;
            AC_Q1:     begin n_store = 1'b1; n_fifo = 1'b1; end
            AC_DROP:   n_reject = 1'b1;
            AC_PRI:    n_prio = 1'b1;
            AC_PRI_Q0: begin n_prio = 1'b1; n_store = 1'b1; n_sfifo = 2'd1; end
            AC_PRI_Q1: begin n_prio = 1'b1; n_store = 1'b1; n_fifo = 1'b1; n_sfifo = 2'd2; end
            AC_DIRECT: n_ded = 1'b1;
            default:   ;
         endcase
      end else begin
         n_reject = nomatch_reject;
         n_store  = !nomatch_reject;
      end
   end

   // one event lane per enable bit of the second identifier field
   for (genvar g = 0; g < EVT_N; g++) begin : g_evt
      assign n_evt[g] = fin_hit && (elem_act == AC_DIRECT) && elem_aux[OFS_W + g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         eval_idx      <= '0;
         base_q        <= '0;
         len_q         <= '0;
         id_q          <= '0;
         done          <= 1'b0;
         res_match     <= 1'b0;
         res_idx       <= '0;
         res_store     <= 1'b0;
         res_fifo      <= 1'b0;
         res_reject    <= 1'b0;
         res_prio      <= 1'b0;
         res_dedicated <= 1'b0;
         res_dbg_kind  <= 2'd0;
         res_buf_addr  <= '0;
         evt_pulse     <= '0;
         prio_irq      <= 1'b0;
         stat_idx      <= '0;
         stat_fifo     <= 2'd0;
      end else begin
         done      <= 1'b0;
         evt_pulse <= '0;
         prio_irq  <= 1'b0;
         if (launch) begin
            state    <= ST_SCAN;
            eval_idx <= '0;
            base_q   <= list_base;
            len_q    <= len_eff;
            id_q     <= rx_id;
         end else if ((state == ST_SCAN) && !finish) begin
            eval_idx <= eval_idx + IDX_W'(1);
         end
         if (finish) begin
            state         <= ST_IDLE;
            done          <= 1'b1;
            res_match     <= fin_hit;
            res_idx       <= fin_hit ? eval_idx : '0;
            res_store     <= n_store;
            res_fifo      <= n_fifo;
            res_reject    <= n_reject;
            res_prio      <= n_prio;
            res_dedicated <= n_ded;
            res_dbg_kind  <= n_ded ? elem_aux[ID_W-1 -: 2] : 2'd0;
            res_buf_addr  <= n_ded ? buf_base + BUF_AW'(elem_aux[OFS_W-1:0]) : '0;
            evt_pulse     <= n_evt;
            prio_irq      <= n_prio && prio_irq_en;
            if (n_prio) begin
               stat_idx  <= eval_idx;
               stat_fifo <= n_sfifo;
            end
         end
      end
   end
endmodule

// File: rtl/stdid_screen.sv
module stdid_screen
   import stdid_pkg::*;
#(
   parameter int LIST_AW   = 8,
   parameter int MAX_ELEMS = 128,
   parameter int BUF_AW    = 8,
   localparam int IDX_W    = $clog2(MAX_ELEMS),
   localparam int LEN_W    = $clog2(MAX_ELEMS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [LIST_AW-1:0] wr_addr,
   input  logic [31:0]        wr_data,
   input  logic [LIST_AW-1:0] list_base,
   input  logic [LEN_W-1:0]   list_len,
   input  logic [BUF_AW-1:0]  buf_base,
   input  logic               nomatch_reject,
   input  logic               prio_irq_en,
   input  logic               start,
   input  logic [10:0]        rx_id,
   output logic               busy,
   output logic               done,
   output logic               res_match,
   output logic [IDX_W-1:0]   res_idx,
   output logic               res_store,
   output logic               res_fifo,
   output logic               res_reject,
   output logic               res_prio,
   output logic               res_dedicated,
   output logic [1:0]         res_dbg_kind,
   output logic [BUF_AW-1:0]  res_buf_addr,
   output logic [2:0]         evt_pulse,
   output logic               prio_irq,
   output logic [IDX_W-1:0]   stat_idx,
   output logic [1:0]         stat_fifo
);
   if (MAX_ELEMS < 2 || MAX_ELEMS > (1 << LIST_AW)) begin : g_chk_len
      $error("MAX_ELEMS must lie in 2 .. 2**LIST_AW");
   end
   if (BUF_AW < OFS_W) begin : g_chk_buf
      $error("BUF_AW must cover the 6-bit buffer offset");
   end
   if (LIST_AW < IDX_W) begin : g_chk_aw
      $error("LIST_AW too narrow for MAX_ELEMS");
   end

   logic [LIST_AW-1:0] rd_addr;
   logic [31:0]        rd_word;
   elem_t              elem;
   logic [ID_W-1:0]    id_q;
   logic               elem_hit;

   assign elem = elem_t'(rd_word);

   stdid_elem_ram #(.AW(LIST_AW), .DW(32)) u_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rdata (rd_word)
   );

   stdid_elem_match u_match (
      .elem (elem),
      .id   (id_q),
      .hit  (elem_hit)
   );

   stdid_scan_ctl #(
      .LIST_AW   (LIST_AW),
      .MAX_ELEMS (MAX_ELEMS),
      .BUF_AW    (BUF_AW),
      .IDX_W     (IDX_W),
      .LEN_W     (LEN_W)
   ) u_ctl (
      .clk            (clk),
      .rst_n          (rst_n),
      .start          (start),
      .rx_id          (rx_id),
      .list_base      (list_base),
      .list_len       (list_len),
      .buf_base       (buf_base),
      .nomatch_reject (nomatch_reject),
      .prio_irq_en    (prio_irq_en),
      .elem_hit       (elem_hit),
      .elem_act       (elem.act),
      .elem_aux       (elem.id_b),
      .rd_addr        (rd_addr),
      .id_q           (id_q),
      .busy           (busy),
      .done           (done),
      .res_match      (res_match),
      .res_idx        (res_idx),
      .res_store      (res_store),
      .res_fifo       (res_fifo),
      .res_reject     (res_reject),
      .res_prio       (res_prio),
      .res_dedicated  (res_dedicated),
      .res_dbg_kind   (res_dbg_kind),
      .res_buf_addr   (res_buf_addr),
      .evt_pulse      (evt_pulse),
      .prio_irq       (prio_irq),
      .stat_idx       (stat_idx),
      .stat_fifo      (stat_fifo)
   );
endmodule

// File: rtl/stdid_screen_chk.sv
module stdid_screen_chk #(
   parameter int IDX_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             res_match,
   input logic             res_store,
   input logic             res_reject,
   input logic             res_prio,
   input logic             res_dedicated,
   input logic [2:0]       evt_pulse,
   input logic             prio_irq,
   input logic [IDX_W-1:0] stat_idx,
   input logic [1:0]       stat_fifo
);
   // R2: verdict strobe lasts one cycle
   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: end of a scan raises the strobe in the same cycle
   p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R2: strobe never overlaps a running scan
   p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R8: at most one disposition per verdict
   p_one_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $onehot0({res_store, res_reject, res_dedicated}));

   // R11: event lanes only fire with a dedicated-slot verdict
   p_evt_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_pulse) |-> (done && res_dedicated));

   // R9: interrupt only with a priority verdict
   p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      prio_irq |-> (done && res_prio));

   // R9: status moves only on a priority verdict
   p_stat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((done && res_prio) || ($stable(stat_idx) && $stable(stat_fifo))));

   // R9: queue code 3 is never recorded
   p_stat_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stat_fifo != 2'd3);

   // R12: a miss carries neither priority nor a dedicated slot
   p_miss_plain_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !res_match) |-> (!res_prio && !res_dedicated));
endmodule

bind stdid_screen stdid_screen_chk #(.IDX_W(IDX_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (busy),
   .done          (done),
   .res_match     (res_match),
   .res_store     (res_store),
   .res_reject    (res_reject),
   .res_prio      (res_prio),
   .res_dedicated (res_dedicated),
   .evt_pulse     (evt_pulse),
   .prio_irq      (prio_irq),
   .stat_idx      (stat_idx),
   .stat_fifo     (stat_fifo)
);

// File: tb/sim_stdid_screen.sv
module sim_stdid_screen;
   localparam int CLK_PERIOD = 10;
   localparam int LIST_AW    = 8;
   localparam int MAX_ELEMS  = 128;
   localparam int BUF_AW     = 8;
   localparam int IDX_W      = 7;
   localparam int LEN_W      = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               wr_en = 1'b0;
   logic [LIST_AW-1:0] wr_addr = '0;
   logic [31:0]        wr_data = '0;
   logic [LIST_AW-1:0] list_base = '0;
   logic [LEN_W-1:0]   list_len = '0;
   logic [BUF_AW-1:0]  buf_base = '0;
   logic               nomatch_reject = 1'b0;
   logic               prio_irq_en = 1'b0;
   logic               start = 1'b0;
   logic [10:0]        rx_id = '0;
   logic               busy, done, res_match, res_store, res_fifo, res_reject;
   logic               res_prio, res_dedicated, prio_irq;
   logic [IDX_W-1:0]   res_idx, stat_idx;
   logic [1:0]         res_dbg_kind, stat_fifo;
   logic [BUF_AW-1:0]  res_buf_addr;
   logic [2:0]         evt_pulse;

   stdid_screen #(.LIST_AW(LIST_AW), .MAX_ELEMS(MAX_ELEMS), .BUF_AW(BUF_AW)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .list_base(list_base), .list_len(list_len), .buf_base(buf_base),
      .nomatch_reject(nomatch_reject), .prio_irq_en(prio_irq_en),
      .start(start), .rx_id(rx_id), .busy(busy), .done(done),
      .res_match(res_match), .res_idx(res_idx), .res_store(res_store),
      .res_fifo(res_fifo), .res_reject(res_reject), .res_prio(res_prio),
      .res_dedicated(res_dedicated), .res_dbg_kind(res_dbg_kind),
      .res_buf_addr(res_buf_addr), .evt_pulse(evt_pulse), .prio_irq(prio_irq),
      .stat_idx(stat_idx), .stat_fifo(stat_fifo)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   // bench list model
   logic [1:0]  m_ty [MAX_ELEMS];
   logic [2:0]  m_ac [MAX_ELEMS];
   logic [10:0] m_a  [MAX_ELEMS];
   logic [10:0] m_b  [MAX_ELEMS];
   int          m_len = 0;
   logic [IDX_W-1:0] e_sidx = '0;
   logic [1:0]       e_sfifo = '0;

   function automatic logic [35:0] observed();
      return {res_match, res_idx, res_store, res_fifo, res_reject, res_prio,
              res_dedicated, res_dbg_kind, res_buf_addr, evt_pulse, prio_irq,
              stat_idx, stat_fifo};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(input int i, input logic [1:0] ty, input logic [2:0] ac,
                      input logic [10:0] a, input logic [10:0] b);
      m_ty[i] = ty; m_ac[i] = ac; m_a[i] = a; m_b[i] = b;
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = LIST_AW'(int'(list_base) + i);
      wr_data = {ty, ac, a, 5'b10101, b};
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic do_scan(input logic [10:0] id);
      int hit = -1;
      logic ok;
      logic st = 0, fi = 0, rj = 0, pr = 0, dd = 0, irq;
      logic [1:0] dk = 0;
      logic [BUF_AW-1:0] ba = 0;
      logic [2:0] ev = 0;
      logic [2:0] ac = 0;
      int lat, exp_lat;
      string tag;
      for (int i = 0; i < m_len; i++) begin
         ok = 1'b0;
         if (m_ac[i] == 3'd7) ok = (id == m_a[i]);           // R10 exact, kind ignored
         else if (m_ac[i] != 3'd0) begin                      // R6 disabled skipped
            if (m_ty[i] == 2'd0) ok = (id >= m_a[i]) && (id <= m_b[i]);              // R3
            else if (m_ty[i] == 2'd1) ok = (id == m_a[i]) || (id == m_b[i]);         // R4
            else if (m_ty[i] == 2'd2) ok = ((id ^ m_a[i]) & m_b[i]) == 11'd0;        // R5
         end
         if (ok && hit < 0) hit = i;                          // R7 first wins
      end
      if (hit >= 0) begin
         ac = m_ac[hit];
         st = (ac == 1) || (ac == 2) || (ac == 5) || (ac == 6);
         fi = (ac == 2) || (ac == 6);
         rj = (ac == 3);
         pr = (ac >= 4) && (ac <= 6);
         dd = (ac == 7);
         if (dd) begin
            dk = m_b[hit][10:9];
            ev = m_b[hit][8:6];
            ba = buf_base + {2'b00, m_b[hit][5:0]};
         end
         if (pr) begin
            e_sidx  = IDX_W'(hit);
            e_sfifo = (ac == 5) ? 2'd1 : (ac == 6) ? 2'd2 : 2'd0;
         end
         if (dd) tag = "R10";
         else if (pr) tag = "R9";
         else if (ac == 3 || ac == 1 || ac == 2)
            tag = (m_ty[hit] == 0) ? "R3/R8" : (m_ty[hit] == 1) ? "R4/R8" : "R5/R8";
         else tag = "R7";
         exp_lat = hit + 1;
      end else begin
         rj = nomatch_reject;  // R12
         st = !nomatch_reject;
         tag = "R12/R6";
         exp_lat = m_len;
      end
      irq = pr && prio_irq_en;

      @(negedge clk);
      rx_id = id;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      if (exp_lat > 0) chk("R2 busy", 64'(busy), 64'd1);
      while (!done) begin
         @(negedge clk);
         lat++;
      end
      chk("R2 latency", 64'(lat), 64'(exp_lat));
      chk(tag, 64'(observed()),
          64'({hit >= 0, IDX_W'(hit >= 0 ? hit : 0), st, fi, rj, pr, dd, dk, ba, ev, irq,
               e_sidx, e_sfifo}));
      @(negedge clk);
      chk("R11 pulse end", 64'({done, evt_pulse, prio_irq}), 64'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 195000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", 64'({busy, done, observed()}), 64'd0);

      // list A: base 5, eight entries, no-match accepted to queue 0
      list_base = 8'd5; list_len = 8'd8; m_len = 8;
      buf_base = 8'hF0; nomatch_reject = 1'b0; prio_irq_en = 1'b1;
      put(0, 2'd0, 3'd0, 11'h000, 11'h7FF);
      put(1, 2'd3, 3'd1, 11'h000, 11'h7FF);
      put(2, 2'd0, 3'd5, 11'h100, 11'h1FF);
      put(3, 2'd1, 3'd3, 11'h050, 11'h7FF);
      put(4, 2'd2, 3'd2, 11'h400, 11'h700);
      put(5, 2'd3, 3'd7, 11'h033, {2'b00, 3'b101, 6'h3F});
      put(6, 2'd0, 3'd7, 11'h034, {2'b10, 3'b010, 6'h02});
      put(7, 2'd1, 3'd6, 11'h000, 11'h600);
      for (int id = 0; id < 2048; id++) do_scan(11'(id));

      // list B: base wraps past the top of RAM, misses rejected, irq off
      list_base = 8'd252; list_len = 8'd10; m_len = 10;
      buf_base = 8'h10; nomatch_reject = 1'b1; prio_irq_en = 1'b0;
      put(0, 2'd2, 3'd1, 11'h7C0, 11'h7C0);
      put(1, 2'd0, 3'd4, 11'h010, 11'h01F);
      put(2, 2'd1, 3'd2, 11'h123, 11'h321);
      put(3, 2'd0, 3'd3, 11'h200, 11'h2FF);
      put(4, 2'd2, 3'd7, 11'h0AB, {2'b01, 3'b011, 6'h10});
      put(5, 2'd1, 3'd7, 11'h0AC, {2'b11, 3'b100, 6'h00});
      put(6, 2'd0, 3'd1, 11'h7F0, 11'h7F5);
      put(7, 2'd1, 3'd6, 11'h005, 11'h006);
      put(8, 2'd0, 3'd5, 11'h300, 11'h300);
      put(9, 2'd3, 3'd2, 11'h000, 11'h7FF);
      for (int id = 0; id < 2048; id++) do_scan(11'(id));

      // R13: a second start during a scan is ignored
      begin
         int lat;
         @(negedge clk); rx_id = 11'h600; start = 1'b1;
         @(negedge clk); start = 1'b0;
         @(negedge clk); rx_id = 11'h123; start = 1'b1;
         @(negedge clk); start = 1'b0;
         lat = 2;
         while (!done) begin
            @(negedge clk);
            lat++;
         end
         chk("R13 ignored start latency", 64'(lat), 64'd10);
         chk("R13 ignored start verdict", 64'({res_match, res_reject, res_store}), 64'b010);
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R13 no extra done", 64'(done), 64'd0);
         end
      end

      // R2: empty list finishes on the start edge
      list_len = 8'd0; m_len = 0;
      do_scan(11'h123);
      nomatch_reject = 1'b0;
      do_scan(11'h7C1);

      // R13: length above the maximum is clamped
      list_base = 8'd0; list_len = 8'd200; m_len = MAX_ELEMS;
      for (int i = 0; i < MAX_ELEMS - 1; i++) put(i, 2'd0, 3'd0, 11'h000, 11'h7FF);
      put(MAX_ELEMS - 1, 2'd1, 3'd1, 11'h2AA, 11'h2AA);
      do_scan(11'h2AA);
      do_scan(11'h2AB);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule